// File: doc/BRIEF.md
# Taken-Branch Target Cache

This block is a small direct-mapped cache of branch targets. The fetch stage presents its current PC every cycle. If the entry selected by the PC holds a valid tag that equals the upper PC bits, the block flags the instruction as a branch that is expected to be taken. It also drives the cached target as the next fetch address. On a miss the instruction is treated as an ordinary instruction, and the next fetch address is the sequential one.

When a branch resolves, the execute stage reports the branch address, whether it was taken, its real target, and the hit/target pair that fetch saw for it. From these the block updates its table. Only taken branches are kept in the table. A branch that fell through after a hit is removed. A taken branch that missed is installed. A taken branch whose cached target was wrong has its target replaced. Each resolution is also classified by its misprediction penalty. That classification appears on registered result outputs one cycle after the report.

Top module: `tbc_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a taken branch is installed.
- R2: A lookup hits in the same cycle when the entry at index PC[5:2] is valid and its stored tag equals PC[31:6]. On a hit `fetch_next_pc` is the stored target. Update PCs are word-aligned (PC[1:0] = 0).
- R3: On a lookup miss `fetch_hit` is 0 and `fetch_next_pc` is `fetch_pc + 4`.
- R4: A resolution with predicted-hit 0 and taken 1 writes the branch tag and target into its entry, and lookups of that PC hit from the following cycle. It is reported as a misprediction with penalty 2.
- R5: A resolution with predicted-hit 1 and taken 0 invalidates the entry if that entry still holds the branch's tag. It is reported as a misprediction with penalty 2.
- R6: A resolution with predicted-hit 1, taken 1 and a target equal to the predicted target leaves the table unchanged. It reports penalty 0 and no misprediction.
- R7: A resolution with predicted-hit 1, taken 1 and a target different from the predicted target overwrites the entry's target. It reports a misprediction with penalty 2.
- R8: A resolution with predicted-hit 0 and taken 0 leaves the table unchanged and reports penalty 0 and no misprediction.
- R9: `res_valid`, `res_mispredict` and `res_penalty` (the count of lost cycles, 0 or 2) describe the update presented in the previous cycle. Without an update `res_valid` and `res_mispredict` are 0.
- R10: A lookup and an update that touch the same entry in one cycle see the contents from before the update.
- R11: Installing a branch whose index is shared with a different tag replaces the old entry, and the old PC then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | 32 | PC being fetched |
| fetch_hit | output | 1 | Lookup hit: predicted-taken branch |
| fetch_next_pc | output | 32 | Next fetch address |
| upd_valid | input | 1 | A resolved branch is reported |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Branch was taken |
| upd_target | input | 32 | Actual target of the branch |
| upd_pred_hit | input | 1 | Fetch saw a hit for this branch |
| upd_pred_target | input | 32 | Target fetch used on that hit |
| res_valid | output | 1 | Result of the previous cycle's update |
| res_mispredict | output | 1 | That update was mispredicted |
| res_penalty | output | 2 | Penalty cycles of that update (0 or 2) |

## Verification
The lookup is combinational, so `fetch_hit` and `fetch_next_pc` are checked a short delay after the inputs change, within the same cycle, against a reference table that holds the state before that cycle's update. Table changes take effect at the clock edge, so a lookup of an updated PC is checked from the next cycle onward. The result outputs sit one register behind the update. They are therefore sampled just after the following rising edge, while the update inputs are still held. Directed steps cover each resolution class, index aliasing and a same-cycle lookup of an entry being written. Random steps then draw from a small PC pool so that hits, aliases and stale predictions occur often.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int PC_W       = 32;
  localparam int INSN_BYTES = 4;

  typedef enum logic [1:0] {
    PEN_ZERO = 2'd0,
    PEN_TWO  = 2'd2
  } pen_e;

  // Sequential fetch address.
  function automatic logic [PC_W-1:0] seq_next(input logic [PC_W-1:0] pc);
    return pc + PC_W'(INSN_BYTES);
  endfunction

  // Penalty class of a resolution from what fetch saw and what happened.
  function automatic pen_e classify(input logic was_hit, input logic taken,
                                    input logic same_tgt);
    pen_e p;
    unique case ({was_hit, taken})
      2'b11:   p = same_tgt ? PEN_ZERO : PEN_TWO;
      2'b10:   p = PEN_TWO;
      2'b01:   p = PEN_TWO;
      default: p = PEN_ZERO;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/tbc_store.sv
module tbc_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int TAG_W   = 26,
  parameter int TGT_W   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag,
  output logic [TGT_W-1:0] rd_target,
  input  logic [IDX_W-1:0] chk_idx,
  output logic             chk_valid,
  output logic [TAG_W-1:0] chk_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [TGT_W-1:0] wr_target,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [TGT_W-1:0]   tgt_q [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        valid_q[e] <= 1'b0;
        tag_q[e]   <= '0;
        tgt_q[e]   <= '0;
      end
    end else begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (wr_en && wr_idx == IDX_W'(e)) begin
          valid_q[e] <= 1'b1;
          tag_q[e]   <= wr_tag;
          tgt_q[e]   <= wr_target;
        end else if (clr_en && clr_idx == IDX_W'(e)) begin
          valid_q[e] <= 1'b0;
        end
      end
    end
  end

  // Reads return the registered contents: a same-cycle write is not seen.
  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_target = tgt_q[rd_idx];
  assign chk_valid = valid_q[chk_idx];
  assign chk_tag   = tag_q[chk_idx];

  // R4: an install leaves a valid entry carrying the written tag and target
  a_r4_install_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)
              && tgt_q[$past(wr_idx)] == $past(wr_target));

  // R5: a removal leaves the entry invalid
  a_r5_remove_lands: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !valid_q[$past(clr_idx)]);
endmodule

// File: rtl/tbc_resolve.sv
module tbc_resolve
  import tbc_pkg::*;
#(
  parameter int TAG_W = 26
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_valid,
  input  logic            upd_taken,
  input  logic            upd_pred_hit,
  input  logic [PC_W-1:0] upd_target,
  input  logic [PC_W-1:0] upd_pred_target,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic            chk_valid,
  input  logic [TAG_W-1:0] chk_tag,
  output logic            wr_en,
  output logic            clr_en,
  output logic            mispredict,
  output pen_e            penalty
);
  logic same_tgt;
  logic entry_ours;

  assign same_tgt   = (upd_target == upd_pred_target);
  assign entry_ours = chk_valid && (chk_tag == upd_tag);
  assign penalty    = classify(upd_pred_hit, upd_taken, same_tgt);
  assign mispredict = (penalty != PEN_ZERO);

  // Install on a taken miss, rewrite on a taken hit with a stale target.
  assign wr_en  = upd_valid && upd_taken && (!upd_pred_hit || !same_tgt);
  // Remove on a fall-through after a hit, only if the entry is still ours.
  assign clr_en = upd_valid && !upd_taken && upd_pred_hit && entry_ours;

  // R5: an entry is never written and removed in the same cycle
  a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && clr_en));
endmodule

// File: rtl/tbc_top.sv
module tbc_top
  import tbc_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] fetch_pc,
  output logic        fetch_hit,
  output logic [31:0] fetch_next_pc,
  input  logic        upd_valid,
  input  logic [31:0] upd_pc,
  input  logic        upd_taken,
  input  logic [31:0] upd_target,
  input  logic        upd_pred_hit,
  input  logic [31:0] upd_pred_target,
  output logic        res_valid,
  output logic        res_mispredict,
  output logic [1:0]  res_penalty
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int ALIGN = $clog2(INSN_BYTES);
  localparam int TAG_W = PC_W - IDX_W - ALIGN;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [TAG_W-1:0] f_tag, u_tag;
  logic             rd_valid, chk_valid;
  logic [TAG_W-1:0] rd_tag, chk_tag;
  logic [PC_W-1:0]  rd_target;
  logic             wr_en, clr_en, mis_now;
  pen_e             pen_now;

  assign f_idx = fetch_pc[ALIGN +: IDX_W];
  assign f_tag = fetch_pc[PC_W-1 -: TAG_W];
  assign u_idx = upd_pc[ALIGN +: IDX_W];
  assign u_tag = upd_pc[PC_W-1 -: TAG_W];

  tbc_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .TGT_W(PC_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(f_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_target(rd_target),
    .chk_idx(u_idx), .chk_valid(chk_valid), .chk_tag(chk_tag),
    .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(u_tag), .wr_target(upd_target),
    .clr_en(clr_en), .clr_idx(u_idx)
  );

  tbc_resolve #(.TAG_W(TAG_W)) u_resolve (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_taken(upd_taken), .upd_pred_hit(upd_pred_hit),
    .upd_target(upd_target), .upd_pred_target(upd_pred_target), .upd_tag(u_tag),
    .chk_valid(chk_valid), .chk_tag(chk_tag),
    .wr_en(wr_en), .clr_en(clr_en), .mispredict(mis_now), .penalty(pen_now)
  );

  assign fetch_hit     = rd_valid && (rd_tag == f_tag);
  assign fetch_next_pc = fetch_hit ? rd_target : seq_next(fetch_pc);

  logic       res_valid_q, res_mis_q;
  logic [1:0] res_pen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_mis_q   <= 1'b0;
      res_pen_q   <= PEN_ZERO;
    end else begin
      res_valid_q <= upd_valid;
      res_mis_q   <= upd_valid && mis_now;
      res_pen_q   <= upd_valid ? pen_now : PEN_ZERO;
    end
  end

  assign res_valid      = res_valid_q;
  assign res_mispredict = res_mis_q;
  assign res_penalty    = res_pen_q;

  // R2: reported branch addresses are word-aligned
  a_r2_aligned_update: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> upd_pc[ALIGN-1:0] == '0);

  // R4: a taken miss costs two cycles
  a_r4_alloc_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && !upd_pred_hit && upd_taken |=> res_mispredict && res_penalty == 2'd2);

  // R5: a fall-through after a hit costs two cycles
  a_r5_fallthrough_penalty: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_pred_hit && !upd_taken |=> res_mispredict && res_penalty == 2'd2);

  // R6: a correct taken hit is free
  a_r6_clean_hit: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid && upd_pred_hit && upd_taken && upd_target == upd_pred_target
    |=> !res_mispredict && res_penalty == 2'd0);

  // R9: no report, no result
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> !res_valid && !res_mispredict);
endmodule

// File: tb/tbc_top_bench.sv
`timescale 1ns/1ps
module tbc_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_hit;
  logic [31:0] fetch_next_pc;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic        upd_pred_hit = 1'b0;
  logic [31:0] upd_pred_target = '0;
  logic        res_valid, res_mispredict;
  logic [1:0]  res_penalty;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  tbc_top u_tbc_top (.*);

  // reference table
  logic        m_v   [16];
  logic [25:0] m_tag [16];
  logic [31:0] m_tgt [16];

  function automatic logic ref_hit(input logic [31:0] pc);
    return m_v[pc[5:2]] && (m_tag[pc[5:2]] == pc[31:6]);
  endfunction

  function automatic logic [1:0] ref_pen(input logic hit, input logic tk,
                                         input logic match);
    if (hit != tk) return 2'd2;
    if (hit && !match) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [31:0] fpc, input logic uv, input logic [31:0] upc,
                      input logic tk, input logic [31:0] tgt, input logic ph,
                      input logic [31:0] pt);
    logic eh;
    logic [31:0] en;
    logic [1:0] ep;
    @(negedge clk);
    fetch_pc = fpc; upd_valid = uv; upd_pc = upc; upd_taken = tk;
    upd_target = tgt; upd_pred_hit = ph; upd_pred_target = pt;
    #1;
    // R2 R3 R10: lookup sees the table before this cycle's update
    eh = ref_hit(fpc);
    en = eh ? m_tgt[fpc[5:2]] : fpc + 32'd4;
    check("R2 hit", {31'd0, fetch_hit}, {31'd0, eh});
    check("R3 next", fetch_next_pc, en);
    ep = ref_pen(ph, tk, tgt == pt);
    if (uv) begin
      if (tk && (!ph || tgt != pt)) begin
        m_v[upc[5:2]] = 1'b1; m_tag[upc[5:2]] = upc[31:6]; m_tgt[upc[5:2]] = tgt;
      end else if (!tk && ph && ref_hit(upc)) begin
        m_v[upc[5:2]] = 1'b0;
      end
    end
    @(posedge clk); #1;
    // R9: result one edge after the update
    check("R9 res_valid", {31'd0, res_valid}, {31'd0, uv});
    check("R9 mispredict", {31'd0, res_mispredict}, {31'd0, uv && ep != 0});
    if (uv) check("R9 penalty", {30'd0, res_penalty}, {30'd0, ep});
  endtask

  localparam logic [31:0] PA = 32'h0000_1000, PB = 32'h0000_1040, PC = 32'h0000_2004;
  localparam logic [31:0] T1 = 32'h0000_8000, T2 = 32'h0000_9000, T3 = 32'h0000_A000;

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] pool [8];
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: nothing hits after reset
    check("R1 reset miss", {31'd0, fetch_hit}, 32'd0);
    check("R1 res_valid", {31'd0, res_valid}, 32'd0);
    // R4 R10: install A while fetching A; the same-cycle lookup still misses
    step(PA, 1, PA, 1, T1, 0, 0);
    check("R10 res_penalty", {30'd0, res_penalty}, 32'd2);
    // R4: visible next cycle; R6: correct taken hit is free
    step(PA, 1, PA, 1, T1, 1, T1);
    check("R4 installed", {31'd0, m_v[0]}, 32'd1);
    check("R6 no mispredict", {31'd0, res_mispredict}, 32'd0);
    // R7: wrong target rewritten
    step(PA, 1, PA, 1, T2, 1, T1);
    check("R7 mispredict", {31'd0, res_mispredict}, 32'd1);
    step(PA, 0, 0, 0, 0, 0, 0);
    #0 check("R7 new target", m_tgt[0], T2);
    // R11: B aliases A's index and replaces it
    step(PB, 1, PB, 1, T3, 0, 0);
    step(PA, 0, 0, 0, 0, 0, 0);
    check("R11 old pc misses", {31'd0, fetch_hit}, 32'd0);
    // R5: fall-through after hit removes B
    step(PB, 1, PB, 0, 0, 1, T3);
    check("R5 penalty", {30'd0, res_penalty}, 32'd2);
    step(PB, 0, 0, 0, 0, 0, 0);
    check("R5 removed", {31'd0, fetch_hit}, 32'd0);
    // R8: not-taken miss is free and installs nothing
    step(PC, 1, PC, 0, T1, 0, 0);
    check("R8 penalty", {30'd0, res_penalty}, 32'd0);
    step(PC, 0, 0, 0, 0, 0, 0);
    check("R8 no install", {31'd0, fetch_hit}, 32'd0);

    pool[0] = PA; pool[1] = PB; pool[2] = PC; pool[3] = 32'h0000_3000;
    pool[4] = 32'h0000_1004; pool[5] = 32'h0000_403C; pool[6] = 32'h0000_503C;
    pool[7] = 32'h0000_2044;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] up, tg, ptg;
      logic ph;
      up  = pool[$urandom % 8];
      ph  = ref_hit(up);
      ptg = ph ? m_tgt[up[5:2]] : 32'd0;
      if (($urandom % 8) == 0) begin ph = ~ph; ptg = T1; end
      tg  = (($urandom % 4) == 0) ? T2 + {24'd0, 6'($urandom), 2'b00} : (ph ? ptg : T1);
      step(pool[$urandom % 8], ($urandom % 4) != 0, up, $urandom % 2, tg, ph, ptg);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule